// File: doc/BRIEF.md
# Byte-Write Flash Programming Sequencer

This block models the programming side of an on-chip code store. The store is a byte-wide register array that comes out of reset fully erased, with every byte at FFh. A host picks an operation with a two-bit mode input and then strobes a program pulse. In program mode the pulse writes one byte. In erase mode the pulse clears the whole array back to FFh. Verify mode reads array bytes, and signature mode reads a small fixed identification window. The address width is a parameter. The default of 10 bits gives 1K bytes; a setting of 12 gives the full 4K array.

Each program or erase is self-timed: a cycle-count parameter sets its length, and the ready output stays low for that whole time. While a byte write is running, the host can poll the byte being written. A read of that byte shows the inverted bit 7 of the new data, and the true value appears once ready returns high. Programming can only pull bits from 1 to 0. Writing over a byte that is not blank leaves the AND of the old and new values, so restoring a byte needs a chip erase.

Top module: `flash_byte_prog_seq`

## Requirements
- R1: After reset, `rdy` is 1 and a verify read of any address returns FFh.
- R2: Mode encodings are 00 program, 01 erase, 10 verify and 11 signature. A `prog_pulse` sampled high in program mode while `rdy` is 1 starts a write. `rdy` goes low after that edge and stays low for exactly `WRITE_CYCLES` cycles.
- R3: When a write to a blank (FFh) byte completes, a verify read of that byte returns the written data.
- R4: A write to a non-blank byte leaves the old value ANDed with the new data. No bit ever goes from 0 to 1 through programming.
- R5: While a write runs, a verify read of the address being written returns the complement of the new data's bit 7 on bit 7, and the byte's current stored bits on bits 6..0.
- R6: While a write runs, a verify read of any other address returns that address's stored value.
- R7: A `prog_pulse` in erase mode while `rdy` is 1 holds `rdy` low for exactly `ERASE_CYCLES` cycles. Afterwards every byte reads FFh.
- R8: While an erase runs, every verify read returns 00h.
- R9: A program or erase pulse that arrives while `rdy` is 0 has no effect. A pulse in verify or signature mode starts nothing.
- R10: In signature mode, address 030h reads 1Eh and 031h reads 51h. Address 032h reads FFh when `HV_VARIANT` is 1 and 05h when it is 0. Every other address reads 00h.
- R11: `rdata` is registered. It reflects the mode and address sampled at the previous clock edge and does not follow them combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operation select: 00 program, 01 erase, 10 verify, 11 signature |
| addr | input | ADDR_W | Byte address for program, verify and signature reads |
| wdata | input | 8 | Data byte to program |
| prog_pulse | input | 1 | One-cycle strobe that starts a program or erase |
| rdata | output | 8 | Registered read data, with polling status during a write |
| rdy | output | 1 | 1 when idle, 0 while a write or erase runs |

## Verification
A wrong busy counter shows at the ports at once as a `rdy` low time that differs from the parameter, measured to the cycle. A wrong latch of address or data, or a busy pulse that is not ignored, first shows in the polled bit 7 while the write runs. It then shows in the array contents on the first verify read after completion. A merge that sets bits instead of only clearing them, or an erase that misses locations, shows one cycle after the next verify read of the affected byte. For that reason the stimulus revisits a small address set many times.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    MODE_PROG   = 2'b00,
    MODE_ERASE  = 2'b01,
    MODE_VERIFY = 2'b10,
    MODE_SIG    = 2'b11
  } fmode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_ERASE = 2'd2
  } fstate_e;

  // programming can only clear bits
  function automatic logic [DATA_W-1:0] merge_program(input logic [DATA_W-1:0] old_v,
                                                      input logic [DATA_W-1:0] new_v);
    return old_v & new_v;
  endfunction

  // status word seen while a byte write is in flight
  function automatic logic [DATA_W-1:0] poll_word(input logic [DATA_W-1:0] stored,
                                                  input logic [DATA_W-1:0] pending);
    return {~pending[DATA_W-1], stored[DATA_W-2:0]};
  endfunction

  // identification window: ofs is the offset from 030h
  function automatic logic [DATA_W-1:0] sig_byte(input logic in_win,
                                                 input logic [1:0] ofs,
                                                 input logic hv);
    logic [DATA_W-1:0] v;
    v = '0;
    if (in_win) begin
      case (ofs)
        2'd0:    v = 8'h1E;
        2'd1:    v = 8'h51;
        2'd2:    v = hv ? 8'hFF : 8'h05;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 64,
  parameter int ERASE_CYCLES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_pulse,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              idle,
  output logic              wr_busy,
  output logic              er_busy,
  output logic              wr_commit,
  output logic              er_commit,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data
);
  localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  fstate_e            state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               start_wr, start_er, cnt_done;

  assign idle      = (state_q == ST_IDLE);
  assign wr_busy   = (state_q == ST_WRITE);
  assign er_busy   = (state_q == ST_ERASE);
  assign cnt_done  = (cnt_q == '0);
  assign start_wr  = idle && prog_pulse && (mode == MODE_PROG);
  assign start_er  = idle && prog_pulse && (mode == MODE_ERASE);
  assign wr_commit = wr_busy && cnt_done;
  assign er_commit = er_busy && cnt_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else if (start_wr) begin
      state_q  <= ST_WRITE;
      cnt_q    <= CNT_W'(WRITE_CYCLES - 1);
      lat_addr <= addr;
      lat_data <= wdata;
    end else if (start_er) begin
      state_q  <= ST_ERASE;
      cnt_q    <= CNT_W'(ERASE_CYCLES - 1);
    end else if (!idle) begin
      if (cnt_done) state_q <= ST_IDLE;
      else          cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && prog_pulse) |=> ($stable(lat_addr) && $stable(lat_data)));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> wr_busy);
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic              er_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] cur_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_word  = mem_q[rd_addr];
  assign cur_word = mem_q[wr_addr];

  always_ff @(posedge clk) begin
    if (!rst_n || er_commit) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_commit) begin
      mem_q[wr_addr] <= merge_program(mem_q[wr_addr], wr_data);
    end
  end

  // R4
  write_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> ((cur_word & ~$past(cur_word)) == '0));

  // R7
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_commit |=> (cur_word == '1) && (rd_word == '1));
endmodule

// File: rtl/flash_seq_rdpath.sv
module flash_seq_rdpath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter bit HV_VARIANT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              wr_busy,
  input  logic              er_busy,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_data,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] SIG_BASE = ADDR_W'(12'h030);

  logic              poll_hit, sig_win;
  logic [ADDR_W-1:0] sig_ofs;
  logic [DATA_W-1:0] rd_next;

  assign poll_hit = (mode == MODE_VERIFY) && wr_busy && (addr == lat_addr);
  assign sig_ofs  = addr - SIG_BASE;
  assign sig_win  = (addr >= SIG_BASE) && (sig_ofs < ADDR_W'(4));

  always_comb begin
    rd_next = '0;
    case (mode)
      MODE_VERIFY: begin
        if (er_busy)       rd_next = '0;
        else if (poll_hit) rd_next = poll_word(rd_word, lat_data);
        else               rd_next = rd_word;
      end
      MODE_SIG: rd_next = sig_byte(sig_win, sig_ofs[1:0], HV_VARIANT);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

  // R5
  poll_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> (rdata[DATA_W-1] == ~$past(lat_data[DATA_W-1])));

  // R8
  erase_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_VERIFY) && er_busy) |=> (rdata == '0));

  // R10
  sig_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_SIG) && (addr == ADDR_W'(12'h031))) |=> (rdata == 8'h51));
endmodule

// File: rtl/flash_byte_prog_seq.sv
module flash_byte_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 64,
  parameter int ERASE_CYCLES = 512,
  parameter bit HV_VARIANT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              prog_pulse,
  output logic [7:0]        rdata,
  output logic              rdy
);
  logic              idle, wr_busy, er_busy, wr_commit, er_commit;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data, rd_word, cur_word;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_pulse(prog_pulse), .mode(mode),
    .addr(addr), .wdata(wdata), .idle(idle), .wr_busy(wr_busy),
    .er_busy(er_busy), .wr_commit(wr_commit), .er_commit(er_commit),
    .lat_addr(lat_addr), .lat_data(lat_data)
  );

  flash_seq_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .er_commit(er_commit),
    .wr_addr(lat_addr), .wr_data(lat_data), .rd_addr(addr),
    .rd_word(rd_word), .cur_word(cur_word)
  );

  flash_seq_rdpath #(.ADDR_W(ADDR_W), .HV_VARIANT(HV_VARIANT)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .rd_word(rd_word),
    .wr_busy(wr_busy), .er_busy(er_busy), .lat_addr(lat_addr),
    .lat_data(lat_data), .rdata(rdata)
  );

  assign rdy = idle;

  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || er_commit) |=> rdy);
endmodule

// File: tb/flash_byte_prog_seq_tb.sv
module flash_byte_prog_seq_tb_top;
  localparam int AW = 10;
  localparam int WC = 12;
  localparam int EC = 40;
  localparam int CLK_NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b10;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          prog_pulse = 1'b0;
  logic [7:0]    rdata;
  logic          rdy;

  int  n_cmp = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  logic [7:0] exp_mem [1 << AW];

  always #(CLK_NS/2) clk = ~clk;

  flash_byte_prog_seq #(
    .ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .HV_VARIANT(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wdata(wdata),
    .prog_pulse(prog_pulse), .rdata(rdata), .rdy(rdy)
  );

  function automatic logic [7:0] exp_sig(input logic [AW-1:0] a);
    if (a == 10'h030) return 8'h1E;
    if (a == 10'h031) return 8'h51;
    if (a == 10'h032) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_poll(input logic [7:0] old_v, input logic [7:0] d);
    logic [7:0] r;
    r = old_v;
    r[7] = ~d[7];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic verify_read(input string tag, input logic [AW-1:0] a);
    mode = 2'b10; addr = a;
    @(negedge clk);
    check(tag, rdata, exp_mem[a]);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                          input bit poll, input bit intrude);
    logic [7:0] old_v;
    int n;
    old_v = exp_mem[a];
    @(negedge clk);
    mode = 2'b00; addr = a; wdata = d; prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
    n = 0;
    while (!rdy) begin
      n++;
      if (poll && n == 1) begin mode = 2'b10; addr = a; end
      if (poll && n == 2) begin
        check("R5 poll", rdata, exp_poll(old_v, d));
        addr = a ^ 1;
      end
      if (poll && n == 3) check("R6 other", rdata, exp_mem[a ^ 1]);
      if (intrude && n == 4) begin mode = 2'b00; addr = a ^ 2; wdata = 8'h00; prog_pulse = 1'b1; end
      if (intrude && n == 5) begin mode = 2'b01; prog_pulse = 1'b1; end
      if (intrude && n == 6) prog_pulse = 1'b0;
      @(negedge clk);
    end
    check("R2 busy", n, WC);
    exp_mem[a] = old_v & d;
    if (old_v == 8'hFF) verify_read("R3 blank", a);
    else                verify_read("R4 merge", a);
    if (intrude) verify_read("R9 busy", a ^ 2);
  endtask

  task automatic do_erase();
    int n;
    @(negedge clk);
    mode = 2'b01; prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
    n = 0;
    while (!rdy) begin
      n++;
      if (n == 1) begin mode = 2'b10; addr = 10'h005; end
      if (n == 2) check("R8 erase rd", rdata, 8'h00);
      @(negedge clk);
    end
    check("R7 busy", n, EC);
    for (int i = 0; i < (1 << AW); i++) exp_mem[i] = 8'hFF;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) exp_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdy", rdy, 1'b1);
    verify_read("R1 erased", 10'h000);
    verify_read("R1 erased", 10'h3FF);
    verify_read("R1 erased", 10'h123);

    // directed: blank write, then overwrite that only clears bits
    do_write(10'h010, 8'hA5, 1'b1, 1'b0);
    do_write(10'h010, 8'h3C, 1'b1, 1'b1);
    do_write(10'h011, 8'h7F, 1'b1, 1'b0);

    // R11: registered read path
    mode = 2'b10; addr = 10'h010;
    @(negedge clk);
    addr = 10'h200;
    #1;
    check("R11 hold", rdata, exp_mem[10'h010]);
    @(negedge clk);
    check("R11 update", rdata, exp_mem[10'h200]);

    // R9: pulse in verify and signature modes starts nothing
    mode = 2'b10; prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
    check("R9 verify pulse", rdy, 1'b1);
    mode = 2'b11; prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
    check("R9 sig pulse", rdy, 1'b1);

    // random writes over a small address set for many revisits
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom_range(0, 15));
      d = 8'($urandom);
      do_write(a, d, (k % 3) == 0, (k % 5) == 0);
    end

    do_erase();
    for (int k = 0; k < 6; k++) verify_read("R7 filled", AW'($urandom_range(0, 15)));
    verify_read("R7 filled", 10'h3FF);

    do_write(10'h004, 8'h00, 1'b1, 1'b0);
    do_write(10'h3FF, 8'h80, 1'b1, 1'b1);

    for (int k = 0; k < 5; k++) begin
      logic [AW-1:0] sa;
      sa = AW'(10'h02F + k);
      mode = 2'b11; addr = sa;
      @(negedge clk);
      check("R10 sig", rdata, exp_sig(sa));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule